// File: doc/BRIEF.md
# Line-Aligned Transmit Read Burst Sequencer

This block sits in front of a transmit DMA engine that fetches packet data from host memory into a transmit FIFO. Software, or a descriptor engine, hands it a start address and a byte count. It then issues one read request per 4-byte bus word and decides on which word each read burst ends. Between bursts it releases the bus. It raises a channel-yield strobe when its per-channel byte quota has been used up, so that an external arbiter can serve other pending DMA channels. It waits for a new grant before starting the next burst.

With line alignment switched on, the block ends a burst only where the next address falls on a cache-line boundary. This holds when the FIFO runs short of room and when the quota runs out. Every later burst therefore starts line-aligned, which suits hosts that perform poorly on reads that begin partway through a line. With alignment off, either condition ends the burst on the word being accepted. The final word of the transfer always ends the burst, wherever it lies in a line. The start address and byte count are word multiples. The enable and quota inputs are held steady during a transfer.

Top module: `txrd_burst_seq`

## Requirements
- R1: After reset the block is idle: `req_valid_o`, `burst_end_o`, `yield_o` and `done_o` are all low.
- R2: A start pulse while idle with no transfer pending loads the address and byte count. Each burst begins the cycle after the block sees `grant_i` high while idle. During a burst the block issues requests whose addresses run from the start address upward in steps of 4, one per accepted word (`req_valid_o` and `req_ready_i` both high), until byte count / 4 words have been accepted. Between bursts `req_valid_o` is low for exactly one cycle while `grant_i` stays high.
- R3: With `align_en_i` low, a word accepted while `fifo_afull_i` is high is the last word of its burst.
- R4: With `align_en_i` high, a word accepted while `fifo_afull_i` is high ends the burst if the following address has its low log2(line size) bits zero. Otherwise the burst goes on to the first word after which the address is line-aligned, and ends there.
- R5: Once a burst is heading for a line boundary, it ends exactly at that boundary. It neither ends earlier nor runs past it, even if `fifo_afull_i` drops in the meantime.
- R6: With `align_en_i` high, every burst that follows a burst ended by FIFO pressure or quota begins on a line-aligned address.
- R7: A byte counter clears at the start of every burst and grows by 4 per accepted word. The quota is used up on the word that brings it to or beyond `quota_bytes_i`. With `align_en_i` low, that word ends the burst and raises `yield_o`.
- R8: With `align_en_i` high and the quota used up, the burst ends, with `yield_o`, only on a word after which the address is line-aligned.
- R9: A `quota_bytes_i` of zero turns quota handling off: no burst ends and no yield occurs because of the quota.
- R10: The final word of the transfer always ends its burst, with no yield, even mid-line. `done_o` is high for exactly the following cycle.
- R11: `burst_end_o` and `yield_o` are single-cycle strobes, high in the cycle the ending word is accepted. `yield_o` is never high without `burst_end_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe for a new transfer |
| start_addr_i | input | AW (32) | Word-aligned first byte address |
| total_bytes_i | input | CW (16) | Transfer length in bytes, nonzero multiple of 4 |
| align_en_i | input | 1 | Enables line-aligned burst termination |
| quota_bytes_i | input | CW (16) | Per-grant byte quota; zero disables |
| fifo_afull_i | input | 1 | Transmit FIFO almost-full flag |
| grant_i | input | 1 | Bus grant from the external arbiter |
| req_ready_i | input | 1 | Current read request accepted this cycle |
| req_valid_o | output | 1 | A word read request is presented |
| req_addr_o | output | AW (32) | Byte address of the presented request |
| burst_end_o | output | 1 | The word accepted this cycle ends the burst |
| yield_o | output | 1 | Quota used up; hand the bus to other channels |
| done_o | output | 1 | Transfer finished (one cycle) |

## Verification
The sweep covers start offsets across a whole line, lengths below one line, equal to one line and spanning several lines, FIFO pressure arriving on chosen words, and quotas that run out mid-line or not at all. The bench also stalls the ready line in a fixed rhythm. A design that ended a pressure burst at once with alignment on would leave the next burst starting mid-line. A design that re-read the almost-full flag while heading for a boundary would run past that boundary. The bench also targets the final word landing mid-line while a drain is pending: a design that gave alignment priority there would request words beyond the transfer, or raise a yield that does not belong. A quota counter that is not cleared per grant shows up as bursts that end too soon after the first hand-off.

// File: rtl/txrd_pkg.sv
// Package txrd_pkg
// Shared types for the transmit read burst sequencer.
package txrd_pkg;

    // Sequencer phases: waiting for grant, streaming, heading for a
    // line boundary, and the cycle after the final word.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } txrd_state_e;

endpackage

// File: rtl/txrd_addr_gen.sv
// Module txrd_addr_gen
// Holds the running word address and the remaining byte count of a
// transfer, and reports whether the current word is the last one and
// whether the address after it falls on a cache-line boundary.
// Assumes: addresses and counts are multiples of BUS_BYTES, LINE_BYTES
// is a power of two no smaller than BUS_BYTES.
module txrd_addr_gen #(
    parameter int AW         = 32,
    parameter int CW         = 16,
    parameter int LINE_BYTES = 32,
    parameter int BUS_BYTES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] bytes_i,
    input  logic          adv_i,
    output logic [AW-1:0] addr_o,
    output logic          rem_zero_o,
    output logic          last_word_o,
    output logic          line_end_o
);

    localparam int            LB     = $clog2(LINE_BYTES);
    localparam logic [AW-1:0] STEP_A = AW'(BUS_BYTES);
    localparam logic [CW-1:0] STEP_C = CW'(BUS_BYTES);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] rem_q;
    logic [AW-1:0] addr_nxt;

    // Address and remaining-count registers: load on start, step per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load_i) begin
            addr_q <= addr_i;
            rem_q  <= bytes_i;
        end else if (adv_i) begin
            addr_q <= addr_nxt;
            rem_q  <= rem_q - STEP_C;
        end
    end

    // Address of the word after the current one.
    always_comb addr_nxt = addr_q + STEP_A;

    // Boundary detection: a line of one bus word ends after every word.
    generate
        if (LINE_BYTES <= BUS_BYTES) begin : g_word_line
            always_comb line_end_o = 1'b1;
        end else begin : g_multi_word_line
            always_comb line_end_o = (addr_nxt[LB-1:0] == '0);
        end
    endgenerate

    // Status outputs for the sequencer.
    always_comb begin
        addr_o      = addr_q;
        rem_zero_o  = (rem_q == '0);
        last_word_o = (rem_q == STEP_C);
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (addr_o == $past(addr_o) + STEP_A)); // R2
    AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (last_word_o == ($past(rem_q) == 2 * STEP_C))); // R2

endmodule

// File: rtl/txrd_quota_ctr.sv
// Module txrd_quota_ctr
// Counts bytes moved since the current grant began and flags when the
// word now being accepted uses up the per-channel quota.
// Assumes: a single grant never moves 2**CW bytes or more.
module txrd_quota_ctr #(
    parameter int CW        = 16,
    parameter int BUS_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          adv_i,
    input  logic [CW-1:0] quota_i,
    output logic          hit_o
);

    localparam logic [CW:0]   STEP_Q = (CW+1)'(BUS_BYTES);
    localparam logic [CW-1:0] STEP_C = CW'(BUS_BYTES);

    logic [CW-1:0] cnt_q;

    // Per-grant byte counter: cleared when a burst starts, grows per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= cnt_q + STEP_C;
        end
    end

    // Quota reached with the current word, compared one bit wider.
    always_comb hit_o = (quota_i != '0) && (({1'b0, cnt_q} + STEP_Q) >= {1'b0, quota_i});

    AST_QCNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0)); // R7
    AST_QUOTA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (quota_i == '0) |-> !hit_o); // R9

endmodule

// File: rtl/txrd_burst_fsm.sv
// Module txrd_burst_fsm
// Control for the read burst sequencer: waits for grant, streams word
// requests, and picks the word that ends each burst from FIFO pressure,
// quota, line boundary and transfer completion.
// Assumes: align_en_i and the quota stay steady during a transfer.
module txrd_burst_fsm
    import txrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        grant_i,
    input  logic        req_ready_i,
    input  logic        fifo_afull_i,
    input  logic        align_en_i,
    input  logic        rem_zero_i,
    input  logic        last_word_i,
    input  logic        line_end_i,
    input  logic        quota_hit_i,
    output logic        load_o,
    output logic        burst_start_o,
    output logic        adv_o,
    output logic        req_valid_o,
    output logic        burst_end_o,
    output logic        yield_o,
    output logic        done_o
);

    txrd_state_e state_q;
    txrd_state_e state_d;
    logic        cause;
    logic        end_c;
    logic        drain_c;

    // Request presentation and word acceptance.
    always_comb begin
        req_valid_o = (state_q == ST_BURST) || (state_q == ST_DRAIN);
        adv_o       = req_valid_o && req_ready_i;
        cause       = fifo_afull_i || quota_hit_i;
    end

    // End-of-burst decision for the word being accepted.
    always_comb begin
        end_c   = 1'b0;
        drain_c = 1'b0;
        if (adv_o) begin
            if (last_word_i) begin
                end_c = 1'b1;
            end else if (!align_en_i) begin
                end_c = cause;
            end else begin
                end_c   = line_end_i && (cause || (state_q == ST_DRAIN));
                drain_c = !end_c && (cause || (state_q == ST_DRAIN));
            end
        end
        burst_end_o = end_c;
        yield_o     = end_c && !last_word_i && quota_hit_i;
    end

    // Next-state and handshake strobes toward the datapath.
    always_comb begin
        state_d       = state_q;
        load_o        = 1'b0;
        burst_start_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (rem_zero_i) begin
                    load_o = start_i;
                end else if (grant_i) begin
                    burst_start_o = 1'b1;
                    state_d       = ST_BURST;
                end
            end
            ST_BURST, ST_DRAIN: begin
                if (end_c) begin
                    state_d = last_word_i ? ST_DONE : ST_IDLE;
                end else if (drain_c) begin
                    state_d = ST_DRAIN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Completion strobe for the cycle after the final word.
    always_comb done_o = (state_q == ST_DONE);

    AST_YIELD_HAS_END: assert property (@(posedge clk) disable iff (!rst_n)
        yield_o |-> burst_end_o); // R11
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end_o |=> !burst_end_o); // R11
    AST_ALIGNED_END: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_end_o && align_en_i && !last_word_i) |-> line_end_i); // R4
    AST_DRAIN_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && adv_o && !line_end_i && !last_word_i) |-> !burst_end_o); // R5
    AST_UNALIGNED_AFULL_END: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && fifo_afull_i && !align_en_i) |-> burst_end_o); // R3
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && last_word_i) |=> done_o); // R10

endmodule

// File: rtl/txrd_burst_seq.sv
// Module txrd_burst_seq
// Top of the transmit read burst sequencer. Issues one read request per
// bus word of a transfer and ends bursts on FIFO pressure, quota use or
// completion, optionally only at cache-line boundaries.
// Assumes: word-aligned start, nonzero word-multiple length, steady
// enable and quota while a transfer runs.
module txrd_burst_seq #(
    parameter int AW         = 32,
    parameter int CW         = 16,
    parameter int LINE_BYTES = 32,
    parameter int BUS_BYTES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [CW-1:0] total_bytes_i,
    input  logic          align_en_i,
    input  logic [CW-1:0] quota_bytes_i,
    input  logic          fifo_afull_i,
    input  logic          grant_i,
    input  logic          req_ready_i,
    output logic          req_valid_o,
    output logic [AW-1:0] req_addr_o,
    output logic          burst_end_o,
    output logic          yield_o,
    output logic          done_o
);

    logic load;
    logic burst_start;
    logic adv;
    logic rem_zero;
    logic last_word;
    logic line_end;
    logic quota_hit;

    txrd_addr_gen #(
        .AW         (AW),
        .CW         (CW),
        .LINE_BYTES (LINE_BYTES),
        .BUS_BYTES  (BUS_BYTES)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .addr_i      (start_addr_i),
        .bytes_i     (total_bytes_i),
        .adv_i       (adv),
        .addr_o      (req_addr_o),
        .rem_zero_o  (rem_zero),
        .last_word_o (last_word),
        .line_end_o  (line_end)
    );

    txrd_quota_ctr #(
        .CW        (CW),
        .BUS_BYTES (BUS_BYTES)
    ) u_quota (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (burst_start),
        .adv_i   (adv),
        .quota_i (quota_bytes_i),
        .hit_o   (quota_hit)
    );

    txrd_burst_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .grant_i       (grant_i),
        .req_ready_i   (req_ready_i),
        .fifo_afull_i  (fifo_afull_i),
        .align_en_i    (align_en_i),
        .rem_zero_i    (rem_zero),
        .last_word_i   (last_word),
        .line_end_i    (line_end),
        .quota_hit_i   (quota_hit),
        .load_o        (load),
        .burst_start_o (burst_start),
        .adv_o         (adv),
        .req_valid_o   (req_valid_o),
        .burst_end_o   (burst_end_o),
        .yield_o       (yield_o),
        .done_o        (done_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!req_valid_o && !done_o)); // R1
    AST_NO_REQ_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end_o |=> !req_valid_o); // R2

endmodule

// File: tb/txrd_burst_seq_bench.sv
// Bench for txrd_burst_seq: sweeps alignment, start offset, length,
// quota and FIFO-pressure position, and predicts every word arithmetically.
module txrd_burst_seq_bench;

    localparam int AW = 32;
    localparam int CW = 16;
    localparam int LINE = 32;
    localparam int WB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [CW-1:0] total_bytes_i = '0;
    logic          align_en_i = 1'b0;
    logic [CW-1:0] quota_bytes_i = '0;
    logic          fifo_afull_i = 1'b0;
    logic          grant_i = 1'b0;
    logic          req_ready_i = 1'b0;
    logic          req_valid_o;
    logic [AW-1:0] req_addr_o;
    logic          burst_end_o;
    logic          yield_o;
    logic          done_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    txrd_burst_seq #(
        .AW(AW), .CW(CW), .LINE_BYTES(LINE), .BUS_BYTES(WB)
    ) u_txrd_burst_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_addr_i  (start_addr_i),
        .total_bytes_i (total_bytes_i),
        .align_en_i    (align_en_i),
        .quota_bytes_i (quota_bytes_i),
        .fifo_afull_i  (fifo_afull_i),
        .grant_i       (grant_i),
        .req_ready_i   (req_ready_i),
        .req_valid_o   (req_valid_o),
        .req_addr_o    (req_addr_o),
        .burst_end_o   (burst_end_o),
        .yield_o       (yield_o),
        .done_o        (done_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    // One transfer; afull_at is the word index that sees FIFO pressure (-1 none).
    task automatic run_one(input bit al, input int off, input int nw, input int quota, input int afull_at);
        int  ea;
        int  rw;
        int  qb;
        bit  d;
        int  phase;
        int  widx;
        bit  fin;
        bit  prev_cut;
        bit  first;
        bit  rdy;
        bit  af;
        bit  bnd;
        bit  last;
        bit  qhit;
        bit  e_end;
        bit  e_yld;
        string tg;
        ea = 32'h1000 + 64 * (nw % 3) + 4 * off;
        @(negedge clk);
        start_i = 1'b1;
        start_addr_i = AW'(ea);
        total_bytes_i = CW'(nw * WB);
        align_en_i = al;
        quota_bytes_i = CW'(quota);
        grant_i = 1'b1;
        req_ready_i = 1'b0;
        fifo_afull_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        rw = nw; qb = 0; d = 0; phase = 0; widx = 0; fin = 0; prev_cut = 0; first = 0;
        for (int guard = 0; guard < 400 && !fin; guard++) begin
            rdy = (cyc % 3) != 2;
            af = (phase == 1) && rdy && (widx == afull_at);
            req_ready_i = rdy;
            fifo_afull_i = af;
            #1;
            if (phase == 0) begin
                chk(req_valid_o == 1'b0, "R2 gap between bursts", req_valid_o, 0);
                chk(burst_end_o == 1'b0 && yield_o == 1'b0, "R11 no strobe in gap", {burst_end_o, yield_o}, 0);
                phase = 1; qb = 0; d = 0; first = 1;
            end else if (phase == 1) begin
                chk(req_valid_o == 1'b1, "R2 request during burst", req_valid_o, 1);
                if (first && prev_cut && al)
                    chk((req_addr_o % LINE) == 0, "R6 aligned burst start", req_addr_o, ea);
                if (rdy) begin
                    first = 0;
                    chk(req_addr_o == AW'(ea), "R2 word address", req_addr_o, ea);
                    bnd  = ((ea + WB) % LINE) == 0;
                    last = (rw == 1);
                    qhit = (quota != 0) && (qb + WB >= quota);
                    if (last) e_end = 1;
                    else if (!al) e_end = af || qhit;
                    else e_end = bnd && (af || qhit || d);
                    e_yld = e_end && !last && qhit;
                    if (last) tg = "R10 final word ends burst";
                    else if (qhit) tg = al ? "R8 quota end at line" : "R7 quota end";
                    else if (d) tg = "R5 drain to boundary";
                    else if (af) tg = al ? "R4 afull end at line" : "R3 afull end";
                    else tg = (quota == 0) ? "R9 no quota end" : "R2 burst continues";
                    chk(burst_end_o == e_end, tg, burst_end_o, e_end);
                    chk(yield_o == e_yld, "R11 yield strobe", yield_o, e_yld);
                    if (al && !e_end) d = d || af || qhit;
                    ea += WB; rw--; qb += WB; widx++;
                    if (e_end) begin
                        phase = last ? 2 : 0;
                        prev_cut = !last;
                    end
                end else begin
                    chk(burst_end_o == 1'b0 && yield_o == 1'b0, "R11 no strobe on stall", {burst_end_o, yield_o}, 0);
                end
            end else begin
                chk(done_o == 1'b1 && req_valid_o == 1'b0, "R10 done after final word", {done_o, req_valid_o}, 2);
                fin = 1;
            end
            @(negedge clk);
            cyc++;
        end
        #1;
        chk(done_o == 1'b0 && req_valid_o == 1'b0, "R10 done single cycle", {done_o, req_valid_o}, 0);
        if (!fin) chk(1'b0, "R2 transfer never completed", phase, 2);
    endtask

    initial begin
        int qs[3];
        int nws[5];
        int afs[3];
        qs = '{0, 12, 36};
        nws = '{1, 3, 8, 13, 20};
        afs = '{-1, 2, 5};
        repeat (3) @(negedge clk);
        #1;
        chk(req_valid_o == 1'b0 && done_o == 1'b0, "R1 reset idle", {req_valid_o, done_o}, 0);
        chk(burst_end_o == 1'b0 && yield_o == 1'b0, "R1 reset strobes low", {burst_end_o, yield_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(req_valid_o == 1'b0, "R1 idle after reset", req_valid_o, 0);
        for (int a = 0; a < 2; a++)
            for (int o = 0; o < LINE / WB; o++)
                for (int n = 0; n < 5; n++)
                    for (int q = 0; q < 3; q++)
                        for (int f = 0; f < 3; f++)
                            run_one(a[0], o, nws[n], qs[q], afs[f]);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule